// File: doc/BRIEF.md
# Delta-Sigma Pulse-Width Modulator

This block converts a signed multi-bit reference word into a single output bit whose long-run density follows the reference. On each sample tick it takes the reference, subtracts the present output level (the high state stands for positive full scale, the low state for negative full scale), and adds that error to an integrator. The output only moves when the integrated error crosses one of two programmable thresholds, so the switching rate follows the reference and the hysteresis band instead of a fixed carrier period.

A system drives `sampleTick` at its chosen modulation rate, holds `refIn` at the wanted level, and sets the two limits around zero. A wider band gives longer, less frequent pulses. A narrower band gives finer, faster toggling. The output then goes to a load or an external filter.

Top module: `dsig_pwm`

## Requirements
- R1: A synchronous reset, `rst` high at a clock edge, clears the integrator to zero and drives `pwmOut` low.
- R2: On a clock edge with `sampleTick` high, the integrator becomes its old value plus `refIn` minus the output level. The output level is +2^(REF_W-1) while `pwmOut` is 1 and -2^(REF_W-1) while it is 0, and all of these values are taken as signed two's complement.
- R3: The integrator is REF_W+GUARD bits wide and signed. An update that would leave that range clamps to the most positive or the most negative value. It never wraps.
- R4: On a tick where the updated integrator value is greater than or equal to `upperLim`, `pwmOut` becomes 1 at that edge.
- R5: On a tick where the updated value is less than or equal to `lowerLim` and R4 does not apply, `pwmOut` becomes 0 at that edge.
- R6: On a tick where the updated value lies strictly between the two limits, `pwmOut` keeps its previous value.
- R7: On an edge with `sampleTick` low, `refIn` has no effect. The integrator and `pwmOut` both hold.
- R8: If the limits overlap so that a value satisfies both comparisons, the upper comparison wins and `pwmOut` becomes 1.
- R9: With a constant reference and ticks on every cycle, the fraction of ticks with `pwmOut` high over many ticks equals (refIn + 2^(REF_W-1)) / 2^REF_W. The allowed error is a few ticks, bounded by the limit band.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sampleTick | input | 1 | Sample enable; one integration step per high cycle |
| refIn | input | REF_W | Signed reference word |
| upperLim | input | REF_W+GUARD | Signed threshold that switches the output high |
| lowerLim | input | REF_W+GUARD | Signed threshold that switches the output low |
| pwmOut | output | 1 | Modulated one-bit output |

## Verification
The bench builds the block with REF_W = 8 and GUARD = 4. That gives a 12-bit integrator and a full-scale step of ±128, so an error of 255 per tick drives the integrator into clamping within nine ticks. With limits at the integrator's own extremes, the output can only switch through clamping, so saturation, and not wrapping, becomes visible at the output. The same small widths let overlapping limits and long averaging runs of a few hundred ticks resolve the duty fraction to within a couple of ticks.

// File: rtl/dsig_pwm_pkg.sv
package dsig_pwm_pkg;

  // Strobes from the control module to the datapath
  typedef struct packed {
    logic accLoad;    // take one integration step this cycle
    logic levelHigh;  // current output state selects the fed-back level
  } dpCtrl_t;

endpackage

// File: rtl/dsig_pwm_datapath.sv
module dsig_pwm_datapath
  import dsig_pwm_pkg::*;
#(
  parameter int REF_W = 8,
  parameter int INT_W = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  dpCtrl_t                 ctrl,
  input  logic signed [REF_W-1:0] refIn,
  output logic signed [INT_W-1:0] accNext
);

  localparam int EXT_W = INT_W + 1;
  localparam int PAD_W = EXT_W - REF_W;
  localparam logic signed [EXT_W-1:0] FULL   = EXT_W'(2 ** (REF_W - 1));
  localparam logic signed [EXT_W-1:0] SAT_HI = EXT_W'(2 ** (INT_W - 1) - 1);
  localparam logic signed [EXT_W-1:0] SAT_LO = EXT_W'(-(2 ** (INT_W - 1)));

  logic signed [INT_W-1:0] accQ;
  logic signed [EXT_W-1:0] accW;
  logic signed [EXT_W-1:0] refW;
  logic signed [EXT_W-1:0] lvlW;
  logic signed [EXT_W-1:0] sumW;

  always_comb begin
    accW = {accQ[INT_W-1], accQ};
    refW = {{PAD_W{refIn[REF_W-1]}}, refIn};
    lvlW = ctrl.levelHigh ? FULL : -FULL;
    sumW = accW + refW - lvlW;
  end

  // Saturating narrow-down of the one-bit-wider sum
  always_comb begin
    if (sumW > SAT_HI)      accNext = SAT_HI[INT_W-1:0];
    else if (sumW < SAT_LO) accNext = SAT_LO[INT_W-1:0];
    else                    accNext = sumW[INT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)               accQ <= '0;
    else if (ctrl.accLoad) accQ <= accNext;
  end

  // R1: reset clears the integrator
  a_r1_acc_clear: assert property (@(posedge clk) rst |=> accQ == '0);

  // R7: no tick, no change
  a_r7_acc_hold: assert property (@(posedge clk) disable iff (rst)
    !ctrl.accLoad |=> $stable(accQ));

  // R3: a positive step from a positive value never ends lower (no wrap)
  a_r3_no_wrap_up: assert property (@(posedge clk) disable iff (rst)
    (ctrl.accLoad && accQ > 0 && (refW - lvlW) > 0) |=> accQ >= $past(accQ));

  // R3: a negative step from a negative value never ends higher
  a_r3_no_wrap_down: assert property (@(posedge clk) disable iff (rst)
    (ctrl.accLoad && accQ < 0 && (refW - lvlW) < 0) |=> accQ <= $past(accQ));

endmodule

// File: rtl/dsig_pwm_control.sv
module dsig_pwm_control
  import dsig_pwm_pkg::*;
#(
  parameter int INT_W = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sampleTick,
  input  logic signed [INT_W-1:0] accNext,
  input  logic signed [INT_W-1:0] upperLim,
  input  logic signed [INT_W-1:0] lowerLim,
  output dpCtrl_t                 ctrl,
  output logic                    outBit
);

  logic outQ;
  logic hitUpper;
  logic hitLower;

  always_comb begin
    hitUpper       = accNext >= upperLim;
    hitLower       = accNext <= lowerLim;
    ctrl.accLoad   = sampleTick;
    ctrl.levelHigh = outQ;
  end

  // Upper threshold checked first: it wins when the limits overlap
  always_ff @(posedge clk) begin
    if (rst) outQ <= 1'b0;
    else if (sampleTick) begin
      if (hitUpper)      outQ <= 1'b1;
      else if (hitLower) outQ <= 1'b0;
    end
  end

  assign outBit = outQ;

  // R1: reset forces the output low
  a_r1_out_low: assert property (@(posedge clk) rst |=> !outBit);

  // R4 and R8: reaching the upper limit sets the output
  a_r4_set_high: assert property (@(posedge clk) disable iff (rst)
    (sampleTick && accNext >= upperLim) |=> outBit);

  // R5: reaching the lower limit alone clears the output
  a_r5_set_low: assert property (@(posedge clk) disable iff (rst)
    (sampleTick && accNext <= lowerLim && accNext < upperLim) |=> !outBit);

  // R6: inside the band the output holds
  a_r6_band_hold: assert property (@(posedge clk) disable iff (rst)
    (sampleTick && accNext < upperLim && accNext > lowerLim) |=> $stable(outBit));

  // R7: without a tick the output holds
  a_r7_out_hold: assert property (@(posedge clk) disable iff (rst)
    !sampleTick |=> $stable(outBit));

endmodule

// File: rtl/dsig_pwm.sv
module dsig_pwm
  import dsig_pwm_pkg::*;
#(
  parameter  int REF_W = 8,
  parameter  int GUARD = 4,
  localparam int INT_W = REF_W + GUARD
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sampleTick,
  input  logic signed [REF_W-1:0] refIn,
  input  logic signed [INT_W-1:0] upperLim,
  input  logic signed [INT_W-1:0] lowerLim,
  output logic                    pwmOut
);

  dpCtrl_t                 ctrl;
  logic signed [INT_W-1:0] accNext;

  dsig_pwm_datapath #(
    .REF_W(REF_W),
    .INT_W(INT_W)
  ) u_datapath (
    .clk    (clk),
    .rst    (rst),
    .ctrl   (ctrl),
    .refIn  (refIn),
    .accNext(accNext)
  );

  dsig_pwm_control #(
    .INT_W(INT_W)
  ) u_control (
    .clk       (clk),
    .rst       (rst),
    .sampleTick(sampleTick),
    .accNext   (accNext),
    .upperLim  (upperLim),
    .lowerLim  (lowerLim),
    .ctrl      (ctrl),
    .outBit    (pwmOut)
  );

endmodule

// File: tb/dsig_pwm_bench.sv
module dsig_pwm_bench;

  localparam int REF_W = 8;
  localparam int GUARD = 4;
  localparam int INT_W = REF_W + GUARD;
  localparam int FS    = 2 ** (REF_W - 1);
  localparam int SMAX  = 2 ** (INT_W - 1) - 1;
  localparam int SMIN  = -(2 ** (INT_W - 1));

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sampleTick = 1'b0;
  logic signed [REF_W-1:0] refIn = '0;
  logic signed [INT_W-1:0] upperLim = '0;
  logic signed [INT_W-1:0] lowerLim = '0;
  logic pwmOut;

  int nChecks = 0;
  int nFails  = 0;
  int mAcc    = 0;
  bit mOut    = 1'b0;
  int highCnt = 0;
  bit done    = 1'b0;

  logic  expQ[$];
  string tagQ[$];
  logic  monE;
  string monT;

  always #5 clk = ~clk;

  dsig_pwm #(.REF_W(REF_W), .GUARD(GUARD)) u_dsig_pwm (
    .clk(clk), .rst(rst), .sampleTick(sampleTick), .refIn(refIn),
    .upperLim(upperLim), .lowerLim(lowerLim), .pwmOut(pwmOut)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Monitor: compares one expected item per cycle, after the edge
  always @(posedge clk) begin
    #2;
    if (expQ.size() > 0) begin
      monE = expQ.pop_front();
      monT = tagQ.pop_front();
      if (monT == "R9" && pwmOut === 1'b1) highCnt++;
      chk(pwmOut === monE, monT, int'(pwmOut), int'(monE));
    end
  end

  // Driver: one cycle of stimulus plus the expected output after it
  task automatic step(int r, bit tk, string tag);
    int lvl;
    int s;
    @(negedge clk);
    refIn      = r[REF_W-1:0];
    sampleTick = tk;
    if (tk) begin
      lvl = mOut ? FS : -FS;
      s   = mAcc + r - lvl;
      if (s > SMAX) s = SMAX;
      if (s < SMIN) s = SMIN;
      mAcc = s;
      if (s >= int'(upperLim))      mOut = 1'b1;
      else if (s <= int'(lowerLim)) mOut = 1'b0;
    end
    expQ.push_back(mOut);
    tagQ.push_back(tag);
  endtask

  task automatic doReset();
    @(negedge clk);
    sampleTick = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    mAcc = 0;
    mOut = 1'b0;
    chk(pwmOut === 1'b0, "R1", int'(pwmOut), 0);
  endtask

  task automatic setLim(int up, int lo);
    @(negedge clk);
    sampleTick = 1'b0;
    upperLim = up[INT_W-1:0];
    lowerLim = lo[INT_W-1:0];
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    upperLim = 12'sd100;
    lowerLim = -12'sd100;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    doReset();  // R1

    // R2, R4, R5, R6: symmetric band, several references
    for (int i = 0; i < 20; i++) step(0, 1'b1, "R2");
    for (int i = 0; i < 20; i++) step(50, 1'b1, "R4");
    for (int i = 0; i < 20; i++) step(-90, 1'b1, "R5");
    for (int i = 0; i < 12; i++) step(127, 1'b1, "R6");
    for (int i = 0; i < 12; i++) step(-128, 1'b1, "R6");

    // R7: ticks low, wild references must not move anything
    for (int i = 0; i < 6; i++) step((i % 2) ? 127 : -128, 1'b0, "R7");
    for (int i = 0; i < 8; i++) step(10, 1'b1, "R7");

    // R1: reset in the middle of activity
    doReset();
    for (int i = 0; i < 4; i++) step(30, 1'b1, "R1");

    // R8: overlapping limits, first step lands at zero
    setLim(-10, 10);
    doReset();
    step(-128, 1'b1, "R8");
    for (int i = 0; i < 10; i++) step(0, 1'b1, "R8");

    // R3: limits at the integrator extremes, only clamping can switch
    setLim(SMAX, SMIN);
    doReset();
    for (int i = 0; i < 12; i++) step(127, 1'b1, "R3");
    for (int i = 0; i < 20; i++) step(-128, 1'b1, "R3");

    // R9: duty fraction tracks the reference
    setLim(64, -64);
    doReset();
    highCnt = 0;
    for (int i = 0; i < 512; i++) step(64, 1'b1, "R9");
    repeat (2) @(negedge clk);
    chk(highCnt >= 380 && highCnt <= 388, "R9", highCnt, 384);

    doReset();
    highCnt = 0;
    for (int i = 0; i < 512; i++) step(-96, 1'b1, "R9");
    repeat (2) @(negedge clk);
    chk(highCnt >= 60 && highCnt <= 68, "R9", highCnt, 64);

    @(negedge clk);
    sampleTick = 1'b0;
    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule